// File: doc/BRIEF.md
# Eight-Source Maskable Event Interrupt Controller

This block gathers eight equal-priority event sources of a converter sequencer into one status register and drives a single active-high interrupt line. Every event sets its status bit whatever the mask holds. A 16-bit enable register picks which status bits may raise the line. Software reads the status register to find out what happened, and that read clears it. Two of the sources are produced inside the block. One is an address-match event, raised when the sequencer address becomes equal to a 3-bit trigger held in the enable register. The other is a FIFO-depth event, raised when the FIFO count becomes equal to a 5-bit threshold held in the same register.

The remaining sources arrive as one-cycle input pulses: limit crossing, short calibration done, full calibration done and pause. The exception is the wake source, which a small state machine produces. It sits in `WK_ACTIVE` and moves to `WK_STANDBY` when `standby` rises. It moves to `WK_SETTLE` when `standby` falls and there counts `SETTLE_CYCLES` cycles. When the count ends it returns to `WK_ACTIVE` and emits the wake event. If `standby` rises again during `WK_SETTLE`, the machine goes back to `WK_STANDBY` without an event. Source 6 is unused. After writing the enable register, software should read the status register once to discard any event that the write itself caused.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the status register, the enable register and `irq` are all 0.
- R2: Status bit n is set in the cycle after source n fires, whether or not enable bit n is set. Source map: 0 limit, 1 address match, 2 FIFO threshold, 3 short calibration, 4 full calibration, 5 pause, 7 wake.
- R3: `irq` rises one cycle after a status bit is set while its enable bit is 1. `irq` stays low while every set status bit is masked.
- R4: Enable bits 10:8 hold the address trigger. Source 1 fires once, in the first cycle in which `seq_addr` equals the trigger. It does not fire again while the match holds. Right after reset the match counts as already seen.
- R5: Enable bits 15:11 hold the FIFO threshold. Source 2 fires once, in the first cycle in which `fifo_count` equals a nonzero threshold. A threshold of 0 never fires.
- R6: Enable bit 6 always reads 0, and status bit 6 is always 0.
- R7: A read with `reg_sel`=1 returns the status in bits 7:0, with zeros above, and clears the status at that clock edge. `irq` falls one cycle after the status becomes empty.
- R8: An event in the same cycle as a status read stays set after the read.
- R9: The wake event fires exactly `SETTLE_CYCLES` clock edges after the edge that samples `standby` low in `WK_STANDBY`. A rise of `standby` during `WK_SETTLE` cancels the event.
- R10: A write with `reg_sel`=0 loads the enable register at that edge. `reg_sel`=0 reads the enable register. Writes with `reg_sel`=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the enable register, 1 the status register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears status when `reg_sel`=1 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| seq_addr | input | 3 | Current sequencer address |
| fifo_count | input | 5 | Current FIFO fill count |
| limit_evt | input | 1 | Limit-crossing pulse (source 0) |
| zcal_evt | input | 1 | Short calibration done pulse (source 3) |
| fcal_evt | input | 1 | Full calibration done pulse (source 4) |
| pause_evt | input | 1 | Pause pulse (source 5) |
| standby | input | 1 | High while in standby |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The bench holds the address match across several cycles and clears the status in the middle of the hold. A level-sensitive design would set bit 1 again after the read. It sweeps the FIFO count through every value with a zero threshold, which would expose an unguarded comparison when the count is 0. It raises an event in the same cycle as a status read, so a design that lets the clear win would lose that bit. It also re-enters standby during the settling count, so a machine that cannot cancel would raise a wake event it should not. Every cycle, `irq` and the read data are compared against a behavioural model, so a one-cycle error in the timing of `irq` or of the trigger retarget shows up at once.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    typedef enum logic [1:0] {
        WK_ACTIVE  = 2'd0,
        WK_STANDBY = 2'd1,
        WK_SETTLE  = 2'd2
    } wake_state_e;

    localparam int SRC_LIMIT = 0;
    localparam int SRC_ADDR  = 1;
    localparam int SRC_FIFO  = 2;
    localparam int SRC_ZCAL  = 3;
    localparam int SRC_FCAL  = 4;
    localparam int SRC_PAUSE = 5;
    localparam int SRC_NONE  = 6;
    localparam int SRC_WAKE  = 7;
endpackage

// File: rtl/evt_match_edge.sv
module evt_match_edge #(
    parameter int WIDTH       = 3,
    parameter bit ZERO_BLOCKS = 1'b0,
    parameter bit PRIOR_INIT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] value,
    input  logic [WIDTH-1:0] target,
    output logic             hit
);
    logic eq;
    logic eq_q;

    generate
        if (ZERO_BLOCKS) begin : g_zero_off
            assign eq = (target != '0) && (value == target);
            // R5: a zero threshold never produces an event
            p_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (target == '0) |-> !hit);
        end else begin : g_plain
            assign eq = (value == target);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= PRIOR_INIT;
        else        eq_q <= eq;
    end

    assign hit = eq & ~eq_q;

    // R4 / R5: a held match gives one event only
    p_hit_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/evt_wake_fsm.sv
module evt_wake_fsm
    import evt_irq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    output logic wake_evt
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    wake_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WK_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wake_evt = 1'b0;
        unique case (state_q)
            WK_ACTIVE: begin
                if (standby) state_d = WK_STANDBY;
            end
            WK_STANDBY: begin
                if (!standby) begin
                    state_d = WK_SETTLE;
                    cnt_d   = '0;
                end
            end
            WK_SETTLE: begin
                if (standby) begin
                    state_d = WK_STANDBY;
                end else if (cnt_q == LAST) begin
                    state_d  = WK_ACTIVE;
                    wake_evt = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = WK_ACTIVE;
        endcase
    end

    // R9: the wake event ends the settling phase
    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (state_q == WK_ACTIVE));
    // R9: settle counter stays within its window
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WK_SETTLE) |-> (cnt_q <= LAST));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int ADDR_W        = 3,
    parameter int THR_W         = 5,
    parameter int NSRC          = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [2:0]  seq_addr,
    input  logic [4:0]  fifo_count,
    input  logic        limit_evt,
    input  logic        zcal_evt,
    input  logic        fcal_evt,
    input  logic        pause_evt,
    input  logic        standby,
    output logic        irq
);
    localparam int REG_W    = NSRC + ADDR_W + THR_W;
    localparam int ADDR_LSB = NSRC;
    localparam int THR_LSB  = ADDR_LSB + ADDR_W;
    localparam logic [REG_W-1:0] EN_KEEP = ~(REG_W'(1) << SRC_NONE);

    logic [REG_W-1:0] en_q;
    logic [NSRC-1:0]  status_q, status_d, evt_vec;
    logic             addr_hit, fifo_hit, wake_hit;
    logic             rd_clr, wr_en;

    assign rd_clr = reg_rd & reg_sel;
    assign wr_en  = reg_wr & ~reg_sel;

    evt_match_edge #(.WIDTH(ADDR_W), .ZERO_BLOCKS(1'b0), .PRIOR_INIT(1'b1)) u_addr (
        .clk(clk), .rst_n(rst_n), .value(seq_addr),
        .target(en_q[ADDR_LSB +: ADDR_W]), .hit(addr_hit));

    evt_match_edge #(.WIDTH(THR_W), .ZERO_BLOCKS(1'b1), .PRIOR_INIT(1'b0)) u_fifo (
        .clk(clk), .rst_n(rst_n), .value(fifo_count),
        .target(en_q[THR_LSB +: THR_W]), .hit(fifo_hit));

    evt_wake_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_wake (
        .clk(clk), .rst_n(rst_n), .standby(standby), .wake_evt(wake_hit));

    always_comb begin
        evt_vec            = '0;
        evt_vec[SRC_LIMIT] = limit_evt;
        evt_vec[SRC_ADDR]  = addr_hit;
        evt_vec[SRC_FIFO]  = fifo_hit;
        evt_vec[SRC_ZCAL]  = zcal_evt;
        evt_vec[SRC_FCAL]  = fcal_evt;
        evt_vec[SRC_PAUSE] = pause_evt;
        evt_vec[SRC_WAKE]  = wake_hit;
        status_d = (rd_clr ? '0 : status_q) | evt_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            en_q     <= '0;
            irq      <= 1'b0;
        end else begin
            status_q <= status_d;
            if (wr_en) en_q <= reg_wdata & EN_KEEP;
            irq <= |(status_q & en_q[NSRC-1:0]);
        end
    end

    always_comb begin
        reg_rdata = reg_sel ? {{(REG_W-NSRC){1'b0}}, status_q} : en_q;
    end

    // R2: every event is captured regardless of mask
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_vec) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));
    // R7: a quiet read empties the status
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (evt_vec == '0)) |=> (status_q == '0));
    // R8: a colliding event survives the read
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (|evt_vec)) |=> (status_q == $past(evt_vec)));
    // R7: empty status drops the line one cycle later
    p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |=> !irq);
    // R3: with everything masked the line stays low
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[NSRC-1:0] == '0) |=> !irq);
    // R6: unused source bit never set
    p_bit6_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[SRC_NONE] && !en_q[SRC_NONE]);
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
    localparam int WAKE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  seq_addr = '0;
    logic [4:0]  fifo_count = '0;
    logic        limit_evt = 0, zcal_evt = 0, fcal_evt = 0, pause_evt = 0, standby = 0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    evt_irq_ctrl #(.SETTLE_CYCLES(WAKE)) i_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_addr(seq_addr),
        .fifo_count(fifo_count), .limit_evt(limit_evt), .zcal_evt(zcal_evt),
        .fcal_evt(fcal_evt), .pause_evt(pause_evt), .standby(standby), .irq(irq));

    // behavioural reference model
    int m_status, m_en, m_irq, m_am_prev, m_fm_prev, m_mode, m_left;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 0; m_en = 0; m_irq = 0;
            m_am_prev = 1; m_fm_prev = 0; m_mode = 0; m_left = 0;
        end else begin
            int ev, am, fm, thr;
            ev = 0;
            if (limit_evt) ev += 1;
            if (zcal_evt)  ev += 8;
            if (fcal_evt)  ev += 16;
            if (pause_evt) ev += 32;
            am = (int'(seq_addr) == ((m_en >> 8) & 7)) ? 1 : 0;
            if (am == 1 && m_am_prev == 0) ev += 2;
            m_am_prev = am;
            thr = (m_en >> 11) & 31;
            fm = (thr != 0 && int'(fifo_count) == thr) ? 1 : 0;
            if (fm == 1 && m_fm_prev == 0) ev += 4;
            m_fm_prev = fm;
            // mode 0 running, 1 asleep, 2 settling
            if (m_mode == 0) begin
                if (standby) m_mode = 1;
            end else if (m_mode == 1) begin
                if (!standby) begin m_mode = 2; m_left = WAKE; end
            end else begin
                if (standby) m_mode = 1;
                else if (m_left == 1) begin m_mode = 0; ev += 128; end
                else m_left--;
            end
            m_irq = ((m_status & m_en & 255) != 0) ? 1 : 0;
            if (reg_rd && reg_sel) m_status = 0;
            m_status = m_status | ev;
            if (reg_wr && !reg_sel) m_en = int'(reg_wdata) & 'hFFBF;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // compare against the model every cycle, between edges
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            check("R3 irq vs model", int'(irq), m_irq);
            check("R10 rdata vs model", int'(reg_rdata), reg_sel ? m_status : m_en);
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_en(logic [15:0] v);
        @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic read_status(output int v);
        @(negedge clk); reg_sel = 1; reg_rd = 1;
        #1 v = int'(reg_rdata);
        @(negedge clk); reg_rd = 0; reg_sel = 0;
    endtask

    task automatic peek_status(output int v);
        reg_sel = 1; #1 v = int'(reg_rdata); reg_sel = 0;
    endtask

    task automatic pulse(int k);
        @(negedge clk);
        case (k)
            0: limit_evt = 1;
            3: zcal_evt = 1;
            4: fcal_evt = 1;
            default: pause_evt = 1;
        endcase
        @(negedge clk);
        limit_evt = 0; zcal_evt = 0; fcal_evt = 0; pause_evt = 0;
    endtask

    task automatic run();
        int v;
        tick(3);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #1;
        check("R1 irq after reset", int'(irq), 0);
        check("R1 enable after reset", int'(reg_rdata), 0);
        peek_status(v);
        check("R1 status after reset", v, 0);

        // masked capture
        pulse(0); pulse(3); pulse(4); pulse(5);
        tick(2);
        check("R3 masked sources keep irq low", int'(irq), 0);
        read_status(v);
        check("R2 masked events captured", v, 'h39);
        read_status(v);
        check("R7 status cleared by read", v, 0);

        // register map and bit 6
        write_en(16'hFFFF);
        #1 check("R6 R10 enable readback", int'(reg_rdata), 'hFFBF);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_wdata = 16'h00FF;
        @(negedge clk); reg_wr = 0; reg_sel = 0;
        #1 check("R10 status write ignored", int'(reg_rdata), 'hFFBF);
        write_en(16'h0000);
        tick(1);
        read_status(v);
        check("R4 retarget onto current address fires", v, 'h02);

        // address trigger = 5
        write_en(16'h0500);
        for (int a = 1; a <= 5; a++) begin @(negedge clk); seq_addr = 3'(a); end
        tick(2);
        read_status(v);
        check("R4 address match event", v, 'h02);
        tick(3);
        read_status(v);
        check("R4 held match does not refire", v, 0);
        @(negedge clk); seq_addr = 3'd6;

        // FIFO threshold = 3, trigger 7 (no match at 6)
        write_en(16'h1F00);
        for (int c = 0; c <= 4; c++) begin @(negedge clk); fifo_count = 5'(c); end
        tick(2);
        read_status(v);
        check("R5 FIFO threshold event", v, 'h04);
        write_en(16'h0700);
        for (int c = 0; c < 32; c++) begin @(negedge clk); fifo_count = 5'(c); end
        @(negedge clk); fifo_count = 0;
        tick(1);
        read_status(v);
        check("R5 zero threshold silent", v, 0);

        // event colliding with read
        pulse(3);
        @(negedge clk); reg_sel = 1; reg_rd = 1; pause_evt = 1;
        #1 v = int'(reg_rdata);
        check("R7 read returns pending status", v, 'h08);
        @(negedge clk); reg_rd = 0; reg_sel = 0; pause_evt = 0;
        read_status(v);
        check("R8 colliding event survives read", v, 'h20);

        // wake sequencing
        @(negedge clk); standby = 1;
        tick(3);
        @(negedge clk); standby = 0;
        tick(WAKE - 1);
        @(negedge clk); peek_status(v);
        check("R9 no wake before settle ends", v, 0);
        @(negedge clk); peek_status(v);
        check("R9 wake after settle", v, 'h80);
        read_status(v);
        @(negedge clk); standby = 1;
        tick(2);
        @(negedge clk); standby = 0;
        tick(2);
        @(negedge clk); standby = 1;
        tick(WAKE + 4);
        read_status(v);
        check("R9 standby re-entry cancels wake", v, 0);
        @(negedge clk); standby = 0;
        tick(WAKE + 2);
        read_status(v);
        check("R9 wake after final exit", v, 'h80);

        // unmasked interrupt and release
        write_en(16'h0709);
        tick(1);
        read_status(v);
        pulse(4);
        tick(3);
        check("R3 masked bit leaves irq low", int'(irq), 0);
        pulse(0);
        #1 check("R3 irq not yet high", int'(irq), 0);
        @(negedge clk); #1 check("R3 irq high after unmasked event", int'(irq), 1);
        read_status(v);
        check("R2 both bits present", v, 'h11);
        #1 check("R7 irq still high right after read", int'(irq), 1);
        @(negedge clk); #1 check("R7 irq drops after clear", int'(irq), 0);
        tick(4);
    endtask

    initial begin
        fork
            run();
            begin
                #2000000;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule